// File: doc/BRIEF.md
# Branch Target Buffer Next-Address Generator

This block sits in the fetch stage and chooses the address to fetch next. It holds a direct-mapped table of branch entries. Each entry has a valid bit, an address tag, a stored target and a two-bit saturating direction counter. In every cycle the current fetch address is looked up combinationally. A hit marks the fetched word as a branch. If the entry's counter also predicts taken, the stored target becomes the next fetch address. In every other case fetch moves on to the following word, four bytes further on.

The execute stage sends back one resolved branch per cycle: its address, whether it was taken, and its real target. A branch that already has an entry trains that entry's counter. A taken branch that has no entry claims the slot at its index and starts in the weakly-taken state. A branch that was not taken and has no entry changes nothing. Writes land on the clock edge, so a lookup in the same cycle still sees the old contents.

Top module: `btb_fetch_unit`

## Requirements
- R1: `next_pc` equals the stored target when the lookup hits and the entry's counter predicts taken. In all other cases it equals `fetch_pc + 4`, and `pred_taken` reflects which of the two was chosen.
- R2: The entry index is `pc[IDX_W+1:2]` and the tag is `pc[ADDR_W-1:IDX_W+2]`. A hit needs a valid entry at that index with an equal tag. On a miss, `pred_branch` is 0 and fetch is sequential.
- R3: Counter values 0 and 1 predict not taken. Values 2 and 3 predict taken.
- R4: A taken outcome raises the counter by one, stopping at 3. A not-taken outcome lowers it by one, stopping at 0.
- R5: From a strong state (0 or 3), a single opposite outcome does not change the prediction. Two opposite outcomes in a row do change it.
- R6: A taken update that misses writes the tag and the target into the slot at its index, sets the counter to 2, and marks the slot valid. It replaces whatever the slot held before.
- R7: An update that hits trains the counter every time. A taken hit also rewrites the target. A not-taken hit keeps both the target and the valid bit.
- R8: Updates take effect on the clock edge. A lookup of the same index in the same cycle returns the contents from before the update.
- R9: A not-taken update that misses leaves every entry unchanged.
- R10: A synchronous active-low reset clears every valid bit, so all lookups miss afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| next_pc | output | ADDR_W | Predicted next fetch address |
| pred_branch | output | 1 | The lookup hit, so the fetched word is a branch |
| pred_taken | output | 1 | The next address is the stored target |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | The resolved branch was taken |
| upd_target | input | ADDR_W | Resolved target of the branch |

## Verification
The bench builds the block with ENTRIES=4 and a 32-bit address. With only four slots, every index can be allocated, swept through every counter state, and driven into conflicts using addresses that share an index but differ in tag. Each counter is taken from strong not-taken up to strong taken and back down. The next address is checked against an arithmetic model after every outcome, including lookups made in the same cycle as an update to the same index.

// File: rtl/btb_pkg.sv
// Package: shared types and constants for the branch target buffer.
// Assumes word-aligned instructions of four bytes.
package btb_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'd0;
    localparam ctr_t CTR_WEAK_NT   = 2'd1;
    localparam ctr_t CTR_WEAK_T    = 2'd2;
    localparam ctr_t CTR_STRONG_T  = 2'd3;

    localparam int INSN_BYTES = 4;

    // Upper counter bit is the taken prediction (R3)
    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_ctr_update.sv
// Module: next value of one two-bit saturating direction counter.
// Assumes the caller only applies the result on a training update.
module btb_ctr_update
    import btb_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);

    // Saturating step toward the resolved outcome (R4)
    always_comb begin
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        end
    end

    // A taken outcome never lowers the count; a not-taken one never raises it
    always_comb begin
        if (taken) begin
            AST_CTR_NO_DROP: assert (nxt >= cur); // R4
        end else begin
            AST_CTR_NO_RISE: assert (nxt <= cur); // R4
        end
    end

endmodule

// File: rtl/btb_store.sv
// Module: direct-mapped entry storage with combinational lookup and
// edge-written install or train. Assumes ENTRIES is a power of two, >= 2.
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    output ctr_t              lk_ctr,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    ctr_t               ctr_q [ENTRIES];
    ctr_t               ctr_trained [ENTRIES];

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] up_idx;
    logic [TAG_W-1:0] up_tag;
    logic             up_hit;

    // Split both addresses into index and tag fields (R2)
    always_comb begin
        lk_idx = lk_pc[IDX_W+1:2];
        lk_tag = lk_pc[ADDR_W-1:IDX_W+2];
        up_idx = up_pc[IDX_W+1:2];
        up_tag = up_pc[ADDR_W-1:IDX_W+2];
    end

    // Read port: tag compare against the indexed slot (R2, R8)
    always_comb begin
        lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_target = tgt_q[lk_idx];
        lk_ctr    = ctr_q[lk_idx];
    end

    // Update port: does the resolved branch already own its slot
    always_comb begin
        up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
    end

    // One counter stepper per slot
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
        btb_ctr_update u_step (
            .cur   (ctr_q[e]),
            .taken (up_taken),
            .nxt   (ctr_trained[e])
        );
    end

    // Install on taken miss, train on hit, clear valids on reset (R6, R7, R9, R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (up_valid) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (up_idx == IDX_W'(e)) begin
                    if (up_hit) begin
                        ctr_q[e] <= ctr_trained[e];
                        if (up_taken) begin
                            tgt_q[e] <= up_target;
                        end
                    end else if (up_taken) begin
                        valid_q[e] <= 1'b1;
                        tag_q[e]   <= up_tag;
                        tgt_q[e]   <= up_target;
                        ctr_q[e]   <= CTR_WEAK_T;
                    end
                end
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0)); // R10

    AST_MISS_NT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && !up_hit) |=> $stable(valid_q)); // R9

    AST_ALLOC_WEAK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !up_hit)
        |=> (valid_q[$past(up_idx)] && (ctr_q[$past(up_idx)] == CTR_WEAK_T))); // R6

    AST_HIT_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit) |=> valid_q[$past(up_idx)]); // R7

endmodule

// File: rtl/btb_next_pc.sv
// Module: chooses between the stored target and the sequential address.
// Assumes the lookup result is settled within the same cycle.
module btb_next_pc
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              hit,
    input  logic [ADDR_W-1:0] target,
    input  ctr_t              ctr,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_taken
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    // Redirect only on a hit whose counter leans taken (R1, R3)
    always_comb begin
        pred_taken = hit && ctr_says_taken(ctr);
        next_pc    = pred_taken ? target : fetch_pc + STEP;
    end

endmodule

// File: rtl/btb_fetch_unit.sv
// Module: top of the fetch-stage next-address generator.
// Assumes one lookup and at most one resolved branch per cycle.
module btb_fetch_unit
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_branch,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    logic              lk_hit;
    logic [ADDR_W-1:0] lk_target;
    ctr_t              lk_ctr;

    btb_store #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .lk_ctr    (lk_ctr),
        .up_valid  (upd_valid),
        .up_pc     (upd_pc),
        .up_taken  (upd_taken),
        .up_target (upd_target)
    );

    btb_next_pc #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .fetch_pc   (fetch_pc),
        .hit        (lk_hit),
        .target     (lk_target),
        .ctr        (lk_ctr),
        .next_pc    (next_pc),
        .pred_taken (pred_taken)
    );

    // A hit is what flags the fetched word as a branch (R2)
    always_comb begin
        pred_branch = lk_hit;
    end

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_branch); // R2

    AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (next_pc == fetch_pc + ADDR_W'(INSN_BYTES))); // R1

endmodule

// File: tb/btb_fetch_unit_bench.sv
// Bench: four-entry build, arithmetic reference model, sweeps of every slot.
module btb_fetch_unit_bench;

    localparam int N  = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] next_pc;
    logic          pred_branch;
    logic          pred_taken;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    bit            mv   [N];
    logic [AW-1:0] mtag [N];
    logic [AW-1:0] mtgt [N];
    int            mctr [N];

    btb_fetch_unit #(.ENTRIES(N), .ADDR_W(AW)) u_btb_fetch_unit (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .pred_branch(pred_branch), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    always #4 clk = ~clk;

    function automatic int idx_of(input logic [AW-1:0] pc);
        return int'((pc >> 2) % N);
    endfunction

    function automatic logic [AW-1:0] tag_of(input logic [AW-1:0] pc);
        return pc / (4 * N);
    endfunction

    task automatic model_update(input logic [AW-1:0] pc, input logic t, input logic [AW-1:0] tg);
        int i;
        i = idx_of(pc);
        if (mv[i] && mtag[i] == tag_of(pc)) begin
            if (t) begin
                mctr[i] = (mctr[i] < 3) ? mctr[i] + 1 : 3;
                mtgt[i] = tg;
            end else begin
                mctr[i] = (mctr[i] > 0) ? mctr[i] - 1 : 0;
            end
        end else if (t) begin
            mv[i] = 1; mtag[i] = tag_of(pc); mtgt[i] = tg; mctr[i] = 2;
        end
    endtask

    // Drive one cycle, check outputs against the pre-edge model, then advance
    task automatic step(input string rq, input logic uv, input logic [AW-1:0] upc,
                        input logic ut, input logic [AW-1:0] utg, input logic [AW-1:0] fpc);
        int i;
        bit eh, et;
        logic [AW-1:0] en;
        @(negedge clk);
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg; fetch_pc = fpc;
        #1;
        i  = idx_of(fpc);
        eh = mv[i] && (mtag[i] == tag_of(fpc));
        et = eh && (mctr[i] >= 2);
        en = et ? mtgt[i] : fpc + 32'd4;
        checks++;
        if (pred_branch !== eh || pred_taken !== et || next_pc !== en) begin
            fails++;
            $display("FAIL %s pc=%h actual br=%0b tk=%0b next=%h expected br=%0b tk=%0b next=%h",
                     rq, fpc, pred_branch, pred_taken, next_pc, eh, et, en);
        end
        @(posedge clk);
        if (uv && rst_n) model_update(upc, ut, utg);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        for (int i = 0; i < N; i++) mv[i] = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [9:0] pat;
        logic [AW-1:0] pc;
        logic [AW-1:0] alias_pc;
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mtag[i] = '0; mtgt[i] = '0; mctr[i] = 0;
        end
        do_reset();

        // R10: after reset every slot misses
        for (int e = 0; e < N; e++) step("R10", 0, '0, 0, '0, 32'h0000_2000 + 32'(e * 4));

        // R9: not-taken misses install nothing
        for (int e = 0; e < N; e++) begin
            pc = 32'h0000_3000 + 32'(e * 4);
            step("R9", 1, pc, 0, 32'hDEAD_0000, pc);
            step("R9", 0, '0, 0, '0, pc);
        end

        // R6, R8, R1: taken miss allocates weak taken; same-cycle lookup sees old
        for (int e = 0; e < N; e++) begin
            pc = 32'h0000_0100 + 32'(e * 4);
            step("R8", 1, pc, 1, 32'h0000_8000 + 32'(e * 64), pc);
            step("R6", 0, '0, 0, '0, pc);
        end

        // R2: same index, different tag misses; other words sequential
        for (int e = 0; e < N; e++) begin
            step("R2", 0, '0, 0, '0, 32'h0000_0100 + 32'(e * 4) + 32'(4 * N));
            step("R2", 0, '0, 0, '0, 32'h0001_0100 + 32'(e * 4));
        end

        // R3, R4, R5: walk every slot's counter through all states,
        // training and looking up the same entry in the same cycle
        for (int e = 0; e < N; e++) begin
            pc  = 32'h0000_0100 + 32'(e * 4);
            pat = 10'b01_1111_0_000 ^ 10'(e);  // low bits first
            for (int k = 0; k < 10; k++) begin
                step((k < 5) ? "R4" : "R5", 1, pc, pat[k], 32'h0000_9000 + 32'(k * 4), pc);
            end
            step("R3", 0, '0, 0, '0, pc);
        end

        // R5: from strong taken, one not-taken keeps taken, second flips
        pc = 32'h0000_0104;
        for (int k = 0; k < 3; k++) step("R4", 1, pc, 1, 32'h0000_A000, pc);
        step("R5", 1, pc, 0, '0, pc);
        step("R5", 1, pc, 0, '0, pc);
        step("R5", 0, '0, 0, '0, pc);
        // R5: from strong not-taken, one taken keeps not-taken, second flips
        for (int k = 0; k < 3; k++) step("R4", 1, pc, 0, '0, pc);
        step("R5", 1, pc, 1, 32'h0000_B000, pc);
        step("R5", 1, pc, 1, 32'h0000_B004, pc);
        step("R5", 0, '0, 0, '0, pc);

        // R7: taken hit rewrites the target, not-taken hit keeps it
        pc = 32'h0000_0108;
        step("R7", 1, pc, 1, 32'h0000_C000, pc);
        step("R7", 1, pc, 1, 32'h0000_C100, pc);
        step("R7", 1, pc, 0, 32'h0000_FFFC, pc);
        step("R7", 0, '0, 0, '0, pc);

        // R6: conflicting taken branch replaces the slot; old owner misses
        alias_pc = 32'h0000_0108 + 32'(4 * N * 3);
        step("R6", 1, alias_pc, 1, 32'h0000_D000, alias_pc);
        step("R6", 0, '0, 0, '0, alias_pc);
        step("R6", 0, '0, 0, '0, 32'h0000_0108);

        // R10: reset with entries present clears them
        do_reset();
        for (int e = 0; e < N; e++) step("R10", 0, '0, 0, '0, 32'h0000_0100 + 32'(e * 4));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule